// File: doc/BRIEF.md
# Self-Test Signature Checker with Cellular-Automaton Stimulus

This block wraps a datapath for built-in self-test. After a start pulse it drives the datapath with a pseudo-random pattern from a one-dimensional hybrid cellular automaton. It folds the datapath's response into a 20-bit signature register on every cycle of the run. A cycle counter runs from the start pulse. When the counter reaches a programmed capture time, the signature is frozen and compared once against a reference template.

The template is loaded in advance through a serial scan input. The outcome of the comparison is reduced to one bit that leaves its idle level of 0 only on a match, so an external observer needs to watch a single pin. The datapath itself is outside this block.

Top module: `bist_sig_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `stim` is 0 and `sig_out` is 0. No run is active until `start` is seen.
- R2: On a clock edge with `start` high, the automaton state is loaded from `seed`, and `stim` shows that value one cycle later. A `seed` of zero is replaced by the value 1.
- R3: On every later edge of an active run, automaton bit i takes the XOR of bits i+1 and i-1. Cells outside the array count as 0. Where bit i of the `CA_R150` mask is set, bit i also XORs in its own previous value. With the default mask 8'hA6, bits 1, 2, 5 and 7 use this rule.
- R4: The signature is 0 right after a start. On each running edge before capture it becomes `{s[18:0], s[19]^s[16]}` XOR the zero-extended `resp`.
- R5: The capture happens on the running edge at which the counter equals `cap_time`. The counter is 0 on the first edge after start. On that edge the run ends and `sig_out` becomes 1 exactly when the signature equals the template; otherwise `sig_out` stays 0. The compared signature has absorbed `cap_time` responses.
- R6: After capture, `stim` holds its last value and `sig_out` holds its result until the next start or reset. On the capture edge the automaton still takes one step.
- R7: While no run is active, each clock with `tmpl_shift` high shifts `tmpl_si` into the template's LSB. The template is loaded MSB first, and only the last 20 bits shifted in are kept.
- R8: While a run is active, `tmpl_shift` and `tmpl_si` have no effect on the template.
- R9: A `start` during or after a run reseeds the automaton. It also clears the signature and the counter, and returns `sig_out` to 0 on that edge.
- R10: With `cap_time` of 0, the compare is made on the first running edge against an all-zero signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins (or restarts) a test run |
| seed | input | STIM_W | Automaton seed loaded at start |
| cap_time | input | CNT_W | Counter value at which the signature is compared |
| tmpl_si | input | 1 | Serial template data |
| tmpl_shift | input | 1 | Template shift enable |
| resp | input | RESP_W | Datapath response |
| stim | output | STIM_W | Stimulus to the datapath |
| sig_out | output | 1 | Pass bit, 1 after a matching compare |

## Verification
The stimulus is due one cycle after the start edge, and then changes once per running cycle. The bench compares `stim` against its own automaton model at every falling edge of the run. The pass bit is due on the edge where the counter equals `cap_time`, which is `cap_time`+1 edges after the start edge. The bench feeds exactly `cap_time`+1 responses, one per falling edge, and reads `sig_out` at the falling edge right after the capture edge. It then reads `sig_out` again several cycles later to confirm that the result holds. The expected signature is computed ahead of the run from the stored responses, so the template can be scanned in with it or with one bit flipped.

// File: rtl/bist_sig_ctrl.sv
module bist_sig_ctrl #(
  parameter int STIM_W = 8,
  parameter int RESP_W = 16,
  parameter int CNT_W  = 12,
  parameter int SIG_W  = 20,
  parameter logic [SIG_W-1:0]  SIG_TAPS = 20'h90000,
  parameter logic [STIM_W-1:0] CA_R150  = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STIM_W-1:0] seed,
  input  logic [CNT_W-1:0]  cap_time,
  input  logic              tmpl_si,
  input  logic              tmpl_shift,
  input  logic [RESP_W-1:0] resp,
  output logic [STIM_W-1:0] stim,
  output logic              sig_out
);

  logic              run;
  logic [STIM_W-1:0] ca, ca_nx, seed_eff;
  logic [STIM_W+1:0] ca_pad;
  logic [SIG_W-1:0]  sig, sig_nx, tmpl, resp_x;
  logic [CNT_W-1:0]  cnt;
  logic              hit;

  assign seed_eff = (seed == '0) ? STIM_W'(1) : seed;
  assign ca_pad   = {1'b0, ca, 1'b0};
  assign resp_x   = SIG_W'(resp);
  assign sig_nx   = {sig[SIG_W-2:0], ^(sig & SIG_TAPS)} ^ resp_x;
  assign hit      = run && (cnt == cap_time);
  assign stim     = ca;

  always_comb begin
    for (int i = 0; i < STIM_W; i++)
      ca_nx[i] = ca_pad[i+2] ^ ca_pad[i] ^ (CA_R150[i] & ca[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; ca <= '0; sig <= '0; cnt <= '0; sig_out <= 1'b0;
    end else if (start) begin
      run <= 1'b1; ca <= seed_eff; sig <= '0; cnt <= '0; sig_out <= 1'b0;
    end else if (run) begin
      ca  <= ca_nx;
      cnt <= cnt + 1'b1;
      if (hit) begin
        run     <= 1'b0;
        sig_out <= (sig == tmpl);
      end else begin
        sig <= sig_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tmpl <= '0;
    else if (tmpl_shift && !run && !start)
      tmpl <= {tmpl[SIG_W-2:0], tmpl_si};
  end

  // R2
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (stim != '0));
  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!sig_out && run && sig == '0 && cnt == '0));
  // R5
  capture_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !start) |=> !run);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !hit) |=> $stable(sig_out));
  // R6
  stim_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(stim));
  // R8
  tmpl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(tmpl));

endmodule

// File: tb/bist_sig_ctrl_tb.sv
`timescale 1ns/1ps
module bist_sig_ctrl_tb;
  logic clk = 0, rst_n = 0, start = 0, tmpl_si = 0, tmpl_shift = 0;
  logic [7:0]  seed = 0;
  logic [11:0] cap_time = 0;
  logic [15:0] resp = 0;
  logic [7:0]  stim;
  logic        sig_out;

  int checks = 0, errors = 0;
  logic [15:0] resp_mem [0:63];
  logic [19:0] tmpl_m = 0;
  logic [7:0]  ca_m;

  always #2.5 clk = ~clk;

  bist_sig_ctrl u_dut (.clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .cap_time(cap_time), .tmpl_si(tmpl_si), .tmpl_shift(tmpl_shift),
    .resp(resp), .stim(stim), .sig_out(sig_out));

  function automatic logic [7:0] ca_step(input logic [7:0] c);
    logic [9:0] p = {1'b0, c, 1'b0};
    logic [7:0] m = 8'hA6;
    for (int i = 0; i < 8; i++) ca_step[i] = p[i+2] ^ p[i] ^ (m[i] & c[i]);
  endfunction

  function automatic logic [19:0] sig_of(input int n);
    logic [19:0] s = 0;
    for (int k = 0; k < n; k++) s = {s[18:0], s[19] ^ s[16]} ^ {4'b0, resp_mem[k]};
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); tmpl_shift = 1; tmpl_si = v[i];
      tmpl_m = {tmpl_m[18:0], v[i]};
    end
    @(negedge clk); tmpl_shift = 0;
  endtask

  task automatic do_start(input logic [7:0] sd);
    @(negedge clk); start = 1; seed = sd;
    @(negedge clk); start = 0;
    ca_m = (sd == 0) ? 8'd1 : sd;
    chk(stim == ca_m, "R2 seed load", stim, ca_m);
    chk(sig_out == 0, "R9 cleared at start", sig_out, 0);
  endtask

  task automatic run_test(input logic [7:0] sd, input int cap, input bit junk);
    logic exp;
    cap_time = cap[11:0];
    do_start(sd);
    exp = (tmpl_m == sig_of(cap));
    for (int k = 0; k <= cap; k++) begin
      resp = resp_mem[k];
      if (junk) begin tmpl_shift = 1'($urandom); tmpl_si = 1'($urandom); end
      chk(stim == ca_m, "R3 automaton step", stim, ca_m);
      @(negedge clk);
      ca_m = ca_step(ca_m);
    end
    tmpl_shift = 0;
    chk(sig_out == exp, junk ? "R8 shift ignored in run" : "R5 compare result", sig_out, exp);
    resp = 16'($urandom);
    repeat (3) @(negedge clk);
    chk(stim == ca_m, "R6 stim frozen", stim, ca_m);
    chk(sig_out == exp, "R6 result held", sig_out, exp);
  endtask

  task automatic fill_resp();
    for (int k = 0; k < 64; k++) resp_mem[k] = 16'($urandom);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(stim == 0, "R1 reset stim", stim, 0);
    chk(sig_out == 0, "R1 reset sig_out", sig_out, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(stim == 0 && sig_out == 0, "R1 idle after reset", {stim, sig_out}, 0);

    // R4 R5 directed match
    fill_resp();
    shift_bits(sig_of(10), 20);
    run_test(8'h5A, 10, 0);
    chk(sig_out == 1, "R4 signature matches model", sig_out, 1);

    // R5 single-bit mismatch
    shift_bits(sig_of(10) ^ 20'h00100, 20);
    run_test(8'h5A, 10, 0);
    chk(sig_out == 0, "R5 mismatch gives idle", sig_out, 0);

    // R7 over-shift: junk prefix falls off
    shift_bits({4'hF, sig_of(17)}, 24);
    run_test(8'h3C, 17, 0);
    chk(sig_out == 1, "R7 last 20 bits kept", sig_out, 1);

    // R10 capture at zero
    shift_bits(20'h0, 20);
    run_test(8'h81, 0, 0);
    chk(sig_out == 1, "R10 zero cap zero template", sig_out, 1);
    shift_bits(20'h00001, 20);
    run_test(8'h81, 0, 0);
    chk(sig_out == 0, "R10 zero cap nonzero template", sig_out, 0);

    // R2 zero seed
    shift_bits(sig_of(5), 20);
    run_test(8'h00, 5, 0);

    // R8 junk shifting during the run
    fill_resp();
    shift_bits(sig_of(30), 20);
    run_test(8'hC3, 30, 1);
    chk(sig_out == 1, "R8 template untouched", sig_out, 1);

    // R9 restart after pass and mid-run
    shift_bits(sig_of(12), 20);
    run_test(8'h17, 12, 0);
    cap_time = 12'd40;
    do_start(8'h99);
    repeat (5) @(negedge clk);
    run_test(8'h17, 12, 0);
    chk(sig_out == 1, "R9 restart mid-run then pass", sig_out, 1);

    // random runs
    for (int t = 0; t < 8; t++) begin
      int cap = 1 + int'($urandom_range(60));
      fill_resp();
      shift_bits(sig_of(cap) ^ ((t % 2) ? 20'(1 << $urandom_range(19)) : 20'h0), 20);
      run_test(8'($urandom), cap, t % 3 == 0);
      chk(sig_out == ((t % 2) ? 1'b0 : 1'b1), "R5 random run", sig_out, (t % 2) ? 0 : 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule